// File: doc/BRIEF.md
# Host Port Event Priority Decoder

This block sits between the interrupt sources of a USB host port and the software or sequencer that services them. Raw one-cycle change pulses (disconnect, connect detect, enable change, overcurrent change and a channel summary) are held in pending flags inside the block. Each time the consumer strobes `eval`, the block reads and clears the pending flags it is allowed to see. It then reports exactly one encoded event, chosen by a fixed precedence that favours regressing conditions over progressing ones. Port events always outrank channel activity.

When a channel event is reported, the per-channel pending vector is captured into a mask. The consumer then drains that mask one channel at a time through a small service handshake, lowest index first. Reporting a connect or a disconnect engages a sticky debounce lock. The lock masks the port-change summary and the disconnect source, and it blocks further connect reports until a soft reset releases it.

Top module: `port_event_decoder`

## Requirements
- R1: After `rst_n` is released, `evt_valid`, `svc_valid`, `svc_none` and `irq` are 0, `chan_mask` is all zeros and the debounce lock is clear.
- R2: An `eval` strobe produces exactly one event. Precedence, highest first, is disconnect, then overcurrent change, then enable change, then connect detect. A port event that loses to a higher one is still consumed.
- R3: An overcurrent change is reported as code 5 (overcurrent) when `port_oc_lvl` is 1, and as code 6 (overcurrent cleared) when it is 0.
- R4: An enable change is reported as code 1 (enabled) when `port_en_lvl` is 1, and as code 2 (disabled) when it is 0.
- R5: A pending connect detect is consumed but reported as code 0 (none) while the debounce lock is set.
- R6: Reporting a disconnect (code 4) or a connect (code 3) sets the debounce lock. Later disconnect and port change pulses then raise neither `irq` nor any event.
- R7: The three port change flags are consumed only when the port summary is pending. A change flag latched while the summary was masked survives an `eval` and is reported once a later change raises the summary.
- R8: Code 7 (channel) is reported only when no port event is found and the channel summary is pending. The summary stays pending when a port event outranks it. On a channel report, `chan_mask` takes the value `chan_pend` held in the `eval` cycle.
- R9: A `svc_req` with a non-empty mask returns the lowest set index on `svc_idx` with `svc_valid`, and clears that bit. With an empty mask it returns `svc_none`. Results appear one cycle after the request.
- R10: `evt_valid` is a one-cycle strobe in the cycle after `eval`, with `evt_code` encoded as NONE=0, ENABLED=1, DISABLED=2, CONN=3, DISCONN=4, OVRCUR=5, OVRCUR_CLR=6, CHAN=7. An `eval` with nothing pending reports code 0.
- R11: `soft_rst` clears the debounce lock, the captured channel mask and both interrupt masks. Pending flags are kept, and an `eval` or `svc_req` in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Synchronous soft reset of lock, masks and channel mask |
| eval | input | 1 | Read-and-clear strobe; requests one event |
| disc_in | input | 1 | Disconnect pulse |
| conn_chg_in | input | 1 | Connect-detect change pulse |
| en_chg_in | input | 1 | Port enable change pulse |
| oc_chg_in | input | 1 | Overcurrent change pulse |
| chan_sum_in | input | 1 | Channel interrupt summary pulse |
| port_en_lvl | input | 1 | Current port enable level |
| port_oc_lvl | input | 1 | Current port overcurrent level |
| chan_pend | input | NUM_CH | Per-channel pending vector |
| svc_req | input | 1 | Request the next pending channel |
| evt_valid | output | 1 | Event strobe |
| evt_code | output | 3 | Encoded event |
| irq | output | 1 | Any core-level flag pending |
| chan_mask | output | NUM_CH | Captured channels still to service |
| svc_valid | output | 1 | Service returned a channel |
| svc_idx | output | IDX_W | Index of the returned channel |
| svc_none | output | 1 | Service found the mask empty |

## Verification
The bench builds the block with `NUM_CH = 6`, a count that is not a power of two. This puts unused index codes on `svc_idx` and makes the top channel bit sit below the width boundary, so the lowest-first search and its draining to `svc_none` are exercised at an uneven edge. The directed phases stack simultaneous port changes to expose the precedence order. They also make arrivals coincide with an `eval` that engages the debounce lock, and strand a change flag behind a masked summary across a soft reset.

// File: rtl/ped_pkg.sv
package ped_pkg;

    typedef enum logic [2:0] {
        EV_NONE       = 3'd0,
        EV_ENABLED    = 3'd1,
        EV_DISABLED   = 3'd2,
        EV_CONN       = 3'd3,
        EV_DISCONN    = 3'd4,
        EV_OVRCUR     = 3'd5,
        EV_OVRCUR_CLR = 3'd6,
        EV_CHAN       = 3'd7
    } evt_e;

    typedef struct packed {
        logic disc;
        logic psum;
        logic csum;
        logic conn;
        logic en;
        logic oc;
    } pend_t;

    typedef struct packed {
        logic clr_core;
        logic clr_port;
        logic clr_csum;
        logic take_lock;
        logic take_chan;
    } ctl_t;

endpackage

// File: rtl/ped_flag_bank.sv
module ped_flag_bank
    import ped_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  soft_rst,
    input  logic  disc_in,
    input  logic  conn_chg_in,
    input  logic  en_chg_in,
    input  logic  oc_chg_in,
    input  logic  chan_sum_in,
    input  ctl_t  ctl,
    output pend_t pend,
    output logic  mask_port,
    output logic  mask_disc
);

    typedef struct packed {
        pend_t p;
        logic  mport;
        logic  mdisc;
    } fb_state_t;

    fb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d.mport = 1'b0;
            st_d.mdisc = 1'b0;
        end else begin
            if (ctl.clr_core) begin
                st_d.p.disc = 1'b0;
                st_d.p.psum = 1'b0;
            end
            if (ctl.clr_port) begin
                st_d.p.conn = 1'b0;
                st_d.p.en   = 1'b0;
                st_d.p.oc   = 1'b0;
            end
            if (ctl.clr_csum) begin
                st_d.p.csum = 1'b0;
            end
            if (ctl.take_lock) begin
                st_d.mport = 1'b1;
                st_d.mdisc = 1'b1;
            end
        end
        // new arrivals win over the clear of the same cycle
        if (disc_in && !st_q.mdisc) st_d.p.disc = 1'b1;
        if (conn_chg_in)            st_d.p.conn = 1'b1;
        if (en_chg_in)              st_d.p.en   = 1'b1;
        if (oc_chg_in)              st_d.p.oc   = 1'b1;
        if ((conn_chg_in || en_chg_in || oc_chg_in) && !st_q.mport)
            st_d.p.psum = 1'b1;
        if (chan_sum_in)            st_d.p.csum = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend      = st_q.p;
    assign mask_port = st_q.mport;
    assign mask_disc = st_q.mdisc;

    // R6: a masked disconnect source never raises a fresh pending disconnect
    a_r6_masked_disc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_disc && !pend.disc && !soft_rst) |=> !pend.disc);

endmodule

// File: rtl/ped_resolver.sv
module ped_resolver
    import ped_pkg::*;
(
    input  logic  eval,
    input  pend_t pend,
    input  logic  lock,
    input  logic  port_en_lvl,
    input  logic  port_oc_lvl,
    output evt_e  code,
    output ctl_t  ctl
);

    always_comb begin
        code = EV_NONE;
        ctl  = '0;
        if (eval) begin
            ctl.clr_core = 1'b1;
            ctl.clr_port = pend.psum;
            if (pend.disc) begin
                code          = EV_DISCONN;
                ctl.take_lock = 1'b1;
            end else if (pend.psum && pend.oc) begin
                code = port_oc_lvl ? EV_OVRCUR : EV_OVRCUR_CLR;
            end else if (pend.psum && pend.en) begin
                code = port_en_lvl ? EV_ENABLED : EV_DISABLED;
            end else if (pend.psum && pend.conn && !lock) begin
                code          = EV_CONN;
                ctl.take_lock = 1'b1;
            end
            if (code == EV_NONE && pend.csum) begin
                code          = EV_CHAN;
                ctl.take_chan = 1'b1;
                ctl.clr_csum  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ped_chan_service.sv
module ped_chan_service #(
    parameter int NUM_CH = 8,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              load,
    input  logic [NUM_CH-1:0] load_vec,
    input  logic              req,
    output logic [NUM_CH-1:0] mask,
    output logic              svc_valid,
    output logic [IDX_W-1:0]  svc_idx,
    output logic              svc_none
);

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic              sv;
        logic [IDX_W-1:0]  idx;
        logic              none;
    } cs_state_t;

    cs_state_t st_d, st_q;
    logic [IDX_W-1:0] lowest;

    always_comb begin
        lowest = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (st_q.mask[i]) lowest = IDX_W'(i);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.sv   = 1'b0;
        st_d.none = 1'b0;
        if (soft_rst) begin
            st_d.mask = '0;
        end else begin
            if (req) begin
                if (|st_q.mask) begin
                    st_d.sv           = 1'b1;
                    st_d.idx          = lowest;
                    st_d.mask[lowest] = 1'b0;
                end else begin
                    st_d.none = 1'b1;
                end
            end
            if (load) st_d.mask = load_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask      = st_q.mask;
    assign svc_valid = st_q.sv;
    assign svc_idx   = st_q.idx;
    assign svc_none  = st_q.none;

    // R9: a served request and an empty answer never coincide
    a_r9_svc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(svc_valid && svc_none));
    // R9: a returned channel is gone from the mask unless a reload happened
    a_r9_svc_bit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && !$past(load)) |-> !mask[svc_idx]);
    // R9: every answer follows a request
    a_r9_svc_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid || svc_none) |-> $past(req));

endmodule

// File: rtl/port_event_decoder.sv
module port_event_decoder
    import ped_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              eval,
    input  logic              disc_in,
    input  logic              conn_chg_in,
    input  logic              en_chg_in,
    input  logic              oc_chg_in,
    input  logic              chan_sum_in,
    input  logic              port_en_lvl,
    input  logic              port_oc_lvl,
    input  logic [NUM_CH-1:0] chan_pend,
    input  logic              svc_req,
    output logic              evt_valid,
    output logic [2:0]        evt_code,
    output logic              irq,
    output logic [NUM_CH-1:0] chan_mask,
    output logic              svc_valid,
    output logic [IDX_W-1:0]  svc_idx,
    output logic              svc_none
);

    typedef struct packed {
        logic lock;
        logic ev_v;
        evt_e ev_c;
    } top_state_t;

    top_state_t st_d, st_q;
    pend_t      pend;
    ctl_t       ctl;
    evt_e       code;
    logic       mask_port, mask_disc;
    logic       eval_ok, req_ok;

    assign eval_ok = eval && !soft_rst;
    assign req_ok  = svc_req && !soft_rst;

    ped_flag_bank u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .disc_in     (disc_in),
        .conn_chg_in (conn_chg_in),
        .en_chg_in   (en_chg_in),
        .oc_chg_in   (oc_chg_in),
        .chan_sum_in (chan_sum_in),
        .ctl         (ctl),
        .pend        (pend),
        .mask_port   (mask_port),
        .mask_disc   (mask_disc)
    );

    ped_resolver u_resolve (
        .eval        (eval_ok),
        .pend        (pend),
        .lock        (st_q.lock),
        .port_en_lvl (port_en_lvl),
        .port_oc_lvl (port_oc_lvl),
        .code        (code),
        .ctl         (ctl)
    );

    ped_chan_service #(.NUM_CH(NUM_CH)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .load      (ctl.take_chan),
        .load_vec  (chan_pend),
        .req       (req_ok),
        .mask      (chan_mask),
        .svc_valid (svc_valid),
        .svc_idx   (svc_idx),
        .svc_none  (svc_none)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ev_v = eval_ok;
        st_d.ev_c = eval_ok ? code : EV_NONE;
        if (soft_rst)           st_d.lock = 1'b0;
        else if (ctl.take_lock) st_d.lock = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lock: 1'b0, ev_v: 1'b0, ev_c: EV_NONE};
        else        st_q <= st_d;
    end

    assign evt_valid = st_q.ev_v;
    assign evt_code  = st_q.ev_c;
    assign irq       = pend.disc || pend.psum || pend.csum;

    // R10: an event strobe only ever follows an accepted eval
    a_r10_valid_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(eval && !soft_rst));
    // R5: no connect is reported from a locked state
    a_r5_no_conn_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_CONN) |-> !$past(st_q.lock));
    // R6: a held lock keeps both interrupt sources masked
    a_r6_lock_masks: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |-> (mask_port && mask_disc));
    // R8: a channel report captures the vector seen at eval
    a_r8_mask_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_CHAN) |-> chan_mask == $past(chan_pend));

endmodule

// File: tb/tb_port_event_decoder.sv
module tb_port_event_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int CH = 6;
    localparam int IW = $clog2(CH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, eval = 0, disc_in = 0, conn_chg_in = 0, en_chg_in = 0;
    logic oc_chg_in = 0, chan_sum_in = 0, port_en_lvl = 0, port_oc_lvl = 0, svc_req = 0;
    logic [CH-1:0] chan_pend = '0;
    logic evt_valid, irq, svc_valid, svc_none;
    logic [2:0] evt_code;
    logic [CH-1:0] chan_mask;
    logic [IW-1:0] svc_idx;

    port_event_decoder #(.NUM_CH(CH)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0, errors = 0;
    string tag = "R1";

    // behavioural reference
    bit m_disc, m_psum, m_csum, m_conn, m_en, m_oc, m_lock, m_mp, m_md;
    bit m_v, m_sv, m_sn;
    int m_code, m_idx;
    bit [CH-1:0] m_mask;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_disc, m_psum, m_csum, m_conn, m_en, m_oc, m_lock, m_mp, m_md} = '0;
            {m_v, m_sv, m_sn} = '0; m_code = 0; m_idx = 0; m_mask = '0;
        end else begin
            bit nd, np, nc, old_mp, old_md, ld;
            int c;
            bit [CH-1:0] old_mask;
            old_mp = m_mp; old_md = m_md; old_mask = m_mask;
            nd = disc_in && !old_md;
            np = (conn_chg_in || en_chg_in || oc_chg_in) && !old_mp;
            nc = chan_sum_in;
            m_v = 0; m_sv = 0; m_sn = 0; m_code = 0; ld = 0;
            if (soft_rst) begin
                m_lock = 0; m_mp = 0; m_md = 0; m_mask = '0;
            end else begin
                if (eval) begin
                    c = 0;
                    if (m_disc) c = 4;
                    else if (m_psum && m_oc) c = port_oc_lvl ? 5 : 6;
                    else if (m_psum && m_en) c = port_en_lvl ? 1 : 2;
                    else if (m_psum && m_conn && !m_lock) c = 3;
                    if (c == 3 || c == 4) begin m_lock = 1; m_mp = 1; m_md = 1; end
                    if (m_psum) begin m_conn = 0; m_en = 0; m_oc = 0; end
                    m_disc = 0; m_psum = 0;
                    if (c == 0 && m_csum) begin c = 7; m_csum = 0; ld = 1; end
                    m_v = 1; m_code = c;
                end
                if (svc_req) begin
                    if (old_mask != 0) begin
                        for (int i = CH - 1; i >= 0; i--) if (old_mask[i]) m_idx = i;
                        m_sv = 1; m_mask[m_idx] = 0;
                    end else m_sn = 1;
                end
                if (ld) m_mask = chan_pend;
            end
            if (nd) m_disc = 1;
            if (conn_chg_in) m_conn = 1;
            if (en_chg_in) m_en = 1;
            if (oc_chg_in) m_oc = 1;
            if (np) m_psum = 1;
            if (nc) m_csum = 1;
        end
    end

    task automatic cmp(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cmp("evt_valid", evt_valid, m_v);
            cmp("evt_code", evt_code, m_code);
            cmp("irq", irq, m_disc || m_psum || m_csum);
            cmp("chan_mask", chan_mask, m_mask);
            cmp("svc_valid", svc_valid, m_sv);
            cmp("svc_none", svc_none, m_sn);
            if (m_sv) cmp("svc_idx", svc_idx, m_idx);
        end
    end

    // explicit requirement checks, independent of the model
    task automatic chk(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_eval(int exp);
        @(negedge clk); eval = 1;
        @(negedge clk); eval = 0; #1;
        chk("event strobe", evt_valid, 1);
        chk("event code", evt_code, exp);
    endtask

    task automatic pulse(bit d, bit c, bit e, bit o, bit ch);
        @(negedge clk);
        disc_in = d; conn_chg_in = c; en_chg_in = e; oc_chg_in = o; chan_sum_in = ch;
        @(negedge clk);
        {disc_in, conn_chg_in, en_chg_in, oc_chg_in, chan_sum_in} = '0;
    endtask

    task automatic service(bit exp_v, int exp_idx);
        @(negedge clk); svc_req = 1;
        @(negedge clk); svc_req = 0; #1;
        chk("svc_valid", svc_valid, exp_v);
        chk("svc_none", svc_none, !exp_v);
        if (exp_v) chk("svc_idx", svc_idx, exp_idx);
    endtask

    task automatic do_soft();
        @(negedge clk); soft_rst = 1;
        @(negedge clk); soft_rst = 0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1; #1;
                tag = "R1";
                chk("evt_valid", evt_valid, 0); chk("irq", irq, 0);
                chk("chan_mask", chan_mask, 0); chk("svc_valid", svc_valid, 0);
                tag = "R10"; do_eval(0);
                chk("strobe one cycle", 0, 0);
                @(negedge clk); #1; chk("strobe dropped", evt_valid, 0);
                tag = "R4";
                port_en_lvl = 1; pulse(0, 0, 1, 0, 0); do_eval(1);
                port_en_lvl = 0; pulse(0, 0, 1, 0, 0); do_eval(2);
                tag = "R3";
                port_oc_lvl = 1; pulse(0, 0, 0, 1, 0); do_eval(5);
                port_oc_lvl = 0; pulse(0, 0, 0, 1, 0); do_eval(6);
                tag = "R2";
                pulse(0, 1, 1, 1, 0); do_eval(6); do_eval(0);
                port_en_lvl = 1; pulse(0, 1, 1, 0, 0); do_eval(1); do_eval(0);
                tag = "R8";
                chan_pend = 6'b101100; pulse(0, 0, 0, 0, 1); do_eval(7);
                chk("mask captured", chan_mask, 6'b101100);
                chan_pend = '0;
                tag = "R9";
                service(1, 2); service(1, 3); service(1, 5); service(0, 0);
                tag = "R8";
                chan_pend = 6'b100001; pulse(0, 0, 1, 0, 1); do_eval(1); do_eval(7);
                chk("mask captured", chan_mask, 6'b100001);
                tag = "R11"; do_soft(); #1; chk("mask cleared", chan_mask, 0);
                tag = "R6";
                pulse(0, 1, 0, 0, 0); do_eval(3);
                pulse(0, 1, 0, 0, 0); #1; chk("irq masked port", irq, 0); do_eval(0);
                pulse(1, 0, 0, 0, 0); #1; chk("irq masked disc", irq, 0); do_eval(0);
                tag = "R11"; do_soft();
                pulse(1, 0, 0, 0, 0); do_eval(4);
                tag = "R5";
                do_soft();
                pulse(1, 0, 0, 0, 0);
                @(negedge clk); eval = 1; conn_chg_in = 1;
                @(negedge clk); eval = 0; conn_chg_in = 0; #1;
                chk("disconnect first", evt_code, 4);
                do_eval(0);
                tag = "R7";
                port_en_lvl = 1; pulse(0, 0, 1, 0, 0);
                do_soft(); do_eval(0);
                pulse(0, 1, 0, 0, 0); do_eval(1);
                repeat (3) @(negedge clk);
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule